// File: doc/BRIEF.md
# Recalibrate Step Pulse Sequencer

This block returns a floppy drive head to track zero. After a start strobe it issues step pulses toward the outer edge of the disk, one pulse for every two periods of an external step-rate tick. It stops with a clean completion as soon as the track-zero sense is seen high on a tick. If that sense has not appeared once a ceiling number of pulses has been issued, it ends with an error. Two mode bits select the ceiling from four values: the extended-track-range bit and the extended-recalibrate bit. Both bits are captured when the start strobe is accepted.

The sequencer is built around five states. `S_IDLE` waits for a start. `S_GAP` holds the step output low and tests track zero and the ceiling on each tick. `S_HIGH` holds the step output high for one tick period. `S_DONE` and `S_FAIL` each last one cycle and report the outcome.

The transitions are these:
- idle to gap, on a start with track zero low;
- idle to done, on a start with track zero high;
- gap to done, on a tick with track zero high;
- gap to fail, on a tick with the ceiling reached;
- gap to high, on a tick otherwise, which counts one pulse;
- high to gap, on a tick;
- done to idle and fail to idle, unconditionally;
- any state to idle, on a software reset.

Top module: `recal_seq`

## Requirements
- R1: The pulse ceiling depends on the latched bits {xrc, etr}. It is 85 for {0,0}, 3925 for {0,1}, 255 for {1,0} and 4095 for {1,1}.
- R2: If track zero never asserts, exactly the ceiling number of step pulses is issued. Then `error` is high for one cycle, `done` stays low, and `busy` is low from that cycle on.
- R3: Track zero is tested on every tick while step is low, and this test takes precedence over the ceiling test. When track zero is seen, `done` pulses for one cycle with `error` low, and no further pulse follows. This holds even when exactly the ceiling number of pulses has been issued.
- R4: If track zero is high when a start is accepted, `done` is high in the cycle after the start and no step pulse is issued.
- R5: Each step pulse is high for exactly one tick period, and the pulses are separated by at least one tick period low. `dir` is 1 (toward the outer track) whenever `busy` or `step` is high.
- R6: A start strobe is ignored unless the sequencer is idle.
- R7: Both mode bits are latched when a start is accepted. Changing the mode inputs while a sequence runs does not change that sequence's ceiling.
- R8: A software reset takes precedence over start. It aborts any sequence and clears the latched extended-recalibrate bit to 0. In the next cycle `busy`, `step`, `done` and `error` are all low, and no done or error pulse follows the abort.
- R9: After the asynchronous reset, `step`, `dir`, `busy`, `done` and `error` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| start | input | 1 | Start strobe for a recalibrate sequence |
| trk0 | input | 1 | Track-zero sense, high when the head is at track zero |
| tick | input | 1 | Step-rate tick, one-cycle strobe |
| etr_mode | input | 1 | Extended-track-range mode bit |
| xrc_mode | input | 1 | Extended-recalibrate mode bit |
| step | output | 1 | Step pulse to the drive |
| dir | output | 1 | Step direction, 1 = toward the outer track |
| busy | output | 1 | High while stepping |
| done | output | 1 | One-cycle pulse on completion at track zero |
| error | output | 1 | One-cycle pulse when the ceiling is exhausted |

## Verification
The bench runs the sequencer with four kinds of track-zero behaviour:
- Track zero never asserts, under all four mode combinations. This tells apart the four ceilings exactly.
- Track zero asserts after pulse counts that lie above a smaller ceiling but below a larger one. This shows that the selected ceiling, and not a fixed one, governs the run.
- Track zero asserts exactly at the ceiling. This shows that the track-zero test wins over the ceiling test.
- Track zero is already high at start. This separates immediate completion from a run of one pulse.

Further runs check three more things. Mode bits flipped mid-run and a repeated start do not change the outcome. A software reset aborts a run cleanly. Every pulse has the width of one tick period.

// File: rtl/recal_pkg.sv
package recal_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_HIGH,
        S_DONE,
        S_FAIL
    } rstate_t;
endpackage

// File: rtl/recal_limit.sv
module recal_limit #(
    parameter int CNT_W  = 12,
    parameter int LIM_00 = 85,
    parameter int LIM_01 = 3925,
    parameter int LIM_10 = 255,
    parameter int LIM_11 = 4095
) (
    input  logic             etr_q,
    input  logic             xrc_q,
    output logic [CNT_W-1:0] limit
);
    localparam int NSEL = 4;
    localparam int LIMS [NSEL] = '{LIM_00, LIM_01, LIM_10, LIM_11};

    logic [CNT_W-1:0] table_w [NSEL];

    for (genvar i = 0; i < NSEL; i++) begin : g_tab
        assign table_w[i] = CNT_W'(LIMS[i]);
    end

    // index is {xrc, etr}
    assign limit = table_w[{xrc_q, etr_q}];
endmodule

// File: rtl/recal_count.sv
module recal_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             at_limit
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_limit = (cnt == limit);

    // R2: never count past the selected ceiling
    a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !clr |-> cnt < limit);
endmodule

// File: rtl/recal_fsm.sv
module recal_fsm
    import recal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic start,
    input  logic trk0,
    input  logic tick,
    input  logic at_limit,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic latch,
    output logic step,
    output logic dir,
    output logic busy,
    output logic done,
    output logic error
);
    rstate_t state, nxt;

    always_comb begin
        nxt     = state;
        cnt_inc = 1'b0;
        cnt_clr = 1'b0;
        latch   = 1'b0;
        if (soft_rst) begin
            nxt     = S_IDLE;
            cnt_clr = 1'b1;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        latch   = 1'b1;
                        cnt_clr = 1'b1;
                        nxt     = trk0 ? S_DONE : S_GAP;
                    end
                end
                S_GAP: begin
                    if (tick) begin
                        if (trk0) begin
                            nxt = S_DONE;
                        end else if (at_limit) begin
                            nxt = S_FAIL;
                        end else begin
                            nxt     = S_HIGH;
                            cnt_inc = 1'b1;
                        end
                    end
                end
                S_HIGH: begin
                    if (tick) nxt = S_GAP;
                end
                S_DONE:  nxt = S_IDLE;
                S_FAIL:  nxt = S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        step  = (state == S_HIGH);
        busy  = (state == S_GAP) || (state == S_HIGH);
        dir   = busy;
        done  = (state == S_DONE);
        error = (state == S_FAIL);
    end

    // R5: direction toward the outer track while stepping
    a_r5_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> dir);
    // R5: a pulse stays high until the next tick
    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        step && !tick && !soft_rst |=> step);
    // R3: done and error never together
    a_r3_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    // R3: track zero seen on a tick while step low ends with done
    a_r3_trk0_stop: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !step && tick && trk0 && !soft_rst |=> done && !step);
    // R8: software reset clears all activity next cycle
    a_r8_soft_abort: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !busy && !step && !done && !error);
    // R6: a start while busy never drops the sequence without an outcome
    a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !soft_rst |=> busy || done || error);
endmodule

// File: rtl/recal_seq.sv
module recal_seq #(
    parameter int LIM_00 = 85,
    parameter int LIM_01 = 3925,
    parameter int LIM_10 = 255,
    parameter int LIM_11 = 4095
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic start,
    input  logic trk0,
    input  logic tick,
    input  logic etr_mode,
    input  logic xrc_mode,
    output logic step,
    output logic dir,
    output logic busy,
    output logic done,
    output logic error
);
    localparam int MAX_A = (LIM_00 > LIM_01) ? LIM_00 : LIM_01;
    localparam int MAX_B = (LIM_10 > LIM_11) ? LIM_10 : LIM_11;
    localparam int LIM_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(LIM_MAX + 1);

    logic             etr_q, xrc_q;
    logic             latch, cnt_clr, cnt_inc, at_limit;
    logic [CNT_W-1:0] limit;

    // Mode capture; software reset clears the extended-recalibrate bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            etr_q <= 1'b0;
            xrc_q <= 1'b0;
        end else if (soft_rst) begin
            xrc_q <= 1'b0;
        end else if (latch) begin
            etr_q <= etr_mode;
            xrc_q <= xrc_mode;
        end
    end

    recal_limit #(
        .CNT_W(CNT_W), .LIM_00(LIM_00), .LIM_01(LIM_01),
        .LIM_10(LIM_10), .LIM_11(LIM_11)
    ) u_limit (
        .etr_q (etr_q),
        .xrc_q (xrc_q),
        .limit (limit)
    );

    recal_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .limit    (limit),
        .at_limit (at_limit)
    );

    recal_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .start    (start),
        .trk0     (trk0),
        .tick     (tick),
        .at_limit (at_limit),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .latch    (latch),
        .step     (step),
        .dir      (dir),
        .busy     (busy),
        .done     (done),
        .error    (error)
    );

    // R8: extended-recalibrate bit is zero after a software reset
    a_r8_xrc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !xrc_q);
    // R7: latched modes stay put while a sequence runs
    a_r7_modes_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$past(soft_rst) |-> $stable(etr_q) && $stable(xrc_q));
endmodule

// File: tb/recal_seq_tb.sv
`timescale 1ns/1ps
module recal_seq_tb;
    localparam int TDIV  = 4;
    localparam int NEVER = 100000;
    localparam int NV    = 9;
    localparam int V_ETR [NV] = '{0, 1, 0, 1, 0, 0, 1, 0, 0};
    localparam int V_XRC [NV] = '{0, 0, 1, 1, 0, 0, 1, 1, 0};
    localparam int V_TRK [NV] = '{NEVER, NEVER, NEVER, NEVER, 85, 10, 300, 100, 0};
    localparam int V_PUL [NV] = '{85, 3925, 255, 4095, 85, 10, 300, 100, 0};
    localparam int V_ERR [NV] = '{1, 1, 1, 1, 0, 0, 0, 0, 0};

    logic clk = 0, rst_n = 0, soft_rst = 0, start = 0, trk0 = 0, tick = 0;
    logic etr_mode = 0, xrc_mode = 0;
    logic step, dir, busy, done, error;

    int n_tests = 0, n_fail = 0;
    int r_pulses, r_err, r_done, r_badw, r_baddir, r_cyc, r_hung;

    always #4 clk = ~clk;

    recal_seq u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start),
        .trk0(trk0), .tick(tick), .etr_mode(etr_mode), .xrc_mode(xrc_mode),
        .step(step), .dir(dir), .busy(busy), .done(done), .error(error)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input bit e, input bit x, input int ntrk, input bit disturb);
        int cyc;
        int hi;
        bit prev;
        r_pulses = 0; r_err = 0; r_done = 0; r_badw = 0; r_baddir = 0;
        r_cyc = -1; r_hung = 1;
        @(negedge clk);
        etr_mode = e; xrc_mode = x; trk0 = (ntrk == 0); start = 1; tick = 0;
        @(negedge clk);
        start = 0; cyc = 0; hi = 0; prev = 0;
        while (cyc < 40000) begin
            if ((step || busy) && !dir) r_baddir++;
            if (step) begin
                hi++;
                if (!prev) r_pulses++;
            end else if (prev) begin
                if (hi != TDIV) r_badw++;
                hi = 0;
            end
            prev = step;
            if (r_pulses >= ntrk) trk0 = 1;
            if (done || error) begin
                r_done = done; r_err = error; r_cyc = cyc; r_hung = 0;
                break;
            end
            if (disturb && cyc == 20) begin
                etr_mode = ~e; xrc_mode = ~x; start = 1;
            end else begin
                start = 0;
            end
            tick = (cyc % TDIV == TDIV - 1);
            @(negedge clk);
            cyc++;
        end
        tick = 0; start = 0; trk0 = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 step", step, 0); chk("R9 dir", dir, 0); chk("R9 busy", busy, 0);
        chk("R9 done", done, 0); chk("R9 error", error, 0);
        rst_n = 1;
        @(negedge clk);

        // R1 R2 R3 R4 R5: vector table
        for (int i = 0; i < NV; i++) begin
            run_case(V_ETR[i][0], V_XRC[i][0], V_TRK[i], 1'b0);
            chk($sformatf("R1 R2 R3 pulses vec%0d", i), r_pulses, V_PUL[i]);
            chk($sformatf("R2 error vec%0d", i), r_err, V_ERR[i]);
            chk($sformatf("R3 done vec%0d", i), r_done, 1 - V_ERR[i]);
            chk($sformatf("R5 width vec%0d", i), r_badw, 0);
            chk($sformatf("R5 dir vec%0d", i), r_baddir, 0);
            chk($sformatf("hang vec%0d", i), r_hung, 0);
        end

        // R4: done one cycle after start, no pulse
        run_case(1'b1, 1'b1, 0, 1'b0);
        chk("R4 latency", r_cyc, 0);
        chk("R4 pulses", r_pulses, 0);

        // R6 R7: modes flipped and a repeat start mid-run
        run_case(1'b0, 1'b0, NEVER, 1'b1);
        chk("R7 latched ceiling", r_pulses, 85);
        chk("R6 ignored start error", r_err, 1);
        run_case(1'b1, 1'b1, 300, 1'b1);
        chk("R7 latched no error", r_err, 0);
        chk("R6 pulses", r_pulses, 300);

        // R8: software reset mid-run, together with start
        @(negedge clk);
        etr_mode = 0; xrc_mode = 1; start = 1;
        @(negedge clk);
        start = 0;
        repeat (30) begin
            tick = ~tick;
            @(negedge clk);
        end
        tick = 0;
        chk("R8 busy before", busy, 1);
        soft_rst = 1; start = 1;
        @(negedge clk);
        soft_rst = 0; start = 0;
        chk("R8 busy", busy, 0); chk("R8 step", step, 0);
        chk("R8 done", done, 0); chk("R8 error", error, 0);
        begin
            int seen = 0;
            for (int k = 0; k < 20; k++) begin
                tick = (k % 2 == 0);
                @(negedge clk);
                if (done || error || busy || step) seen++;
            end
            tick = 0;
            chk("R8 no outcome after abort", seen, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule